// File: doc/BRIEF.md
# Staged Power-On Reset Sequencer

This block turns one external, active-low reset request into two on-chip reset outputs: one that holds the clock generators (PLLs) and one that holds the processor, memory controller and peripherals. It runs on a free-running reference clock and never on a PLL output. Whenever a reset source is active, both outputs go high at once. When the sources clear, the PLL reset drops after a short delay. The system reset drops later, after a much longer hold measured from the same starting point, so that the external memory has time to settle before calibration begins.

The PLL lock indications are also reset sources. The system reset waits for every PLL to report lock. If lock is lost after it has been seen, the whole sequence starts again. After the system reset drops, the block waits a bounded time for the memory controller to report that initialisation is done. If that report does not come in time, it raises a sticky failure flag. A build option makes it retry the whole sequence after such a failure. A small status code tells which phase the sequencer is in.

All delays are given in milliseconds together with the reference clock rate in kHz. The external reset, the lock inputs and the memory-done input each pass through a two-flop synchroniser. Reset assertion is asynchronous. Every release is synchronous to the reference clock.

Top module: `staged_reset_seq`

## Requirements
- R1: While `extRstN` is low, `pllRst` and `sysRst` are 1, `seqState` is 0 and `initFail` is 0. These values appear as soon as `extRstN` falls, without waiting for a clock edge.
- R2: After `extRstN` rises, `pllRst` goes to 0 at the 3+T-th rising clock edge, where T = CLK_KHZ*PLL_MS.
- R3: With all locks high, `sysRst` goes to 0 at the 3+S-th rising edge after `extRstN` rises, where S = CLK_KHZ*SYS_MS and S > T. `sysRst` is never 0 while `pllRst` is 1.
- R4: Once the PLL reset has been released, `sysRst` stays 1 while any bit of `pllLocked` is 0. When the last lock bit rises after the hold has expired, `sysRst` falls at the third rising edge.
- R5: Once all locks have been seen high, a 0 on any lock bit makes both `pllRst` and `sysRst` 1 and `seqState` 0 at the third rising edge after the drop. The full sequence then runs again.
- R6: If `memInitDone` is high within the timeout, the block stays in running (state 3) with `initFail` 0.
- R7: If `memInitDone` stays low, the block enters init-failed (state 4) at the I-th rising edge after entering running, where I = CLK_KHZ*INIT_MS. At that point `initFail` becomes 1 and `sysRst` stays 0. `initFail` survives lock-loss restarts and is cleared only by `extRstN`.
- R8: With RETRY_ON_FAIL=1, the edge after entering init-failed returns the block to state 0 with both resets 1 and `initFail` still 1.
- R9: `seqState` encodes the phases as 0 idle-reset, 1 PLL-hold, 2 system-hold, 3 running and 4 init-failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| extRstN | input | 1 | External reset request, active low, asynchronous |
| pllLocked | input | NUM_PLL | Lock indication of each PLL, asynchronous |
| memInitDone | input | 1 | Memory controller initialisation finished, asynchronous |
| pllRst | output | 1 | Reset to the PLLs, active high |
| sysRst | output | 1 | Reset to processor, memory controller and peripherals, active high |
| initFail | output | 1 | Sticky flag: memory initialisation timed out |
| seqState | output | 3 | Current sequencer phase |

## Verification
Every result has a fixed latency, measured in rising edges from the falling edge at which the bench changes an input. The releases come 3+T and 3+S edges after `extRstN` rises: two edges for the synchroniser and one for the state machine. A lock rise or drop takes effect three edges later. A timeout becomes visible I edges after the system reset falls. Asynchronous assertion is checked one time unit after `extRstN` falls, with no edge between. The bench sets small clock and millisecond parameters and steps one edge at a time. It samples only at falling edges and records the first edge at which each output changes, then compares that edge number with the computed one.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  // Phase codes are visible on the seqState port.
  typedef enum logic [2:0] {
    ST_RESET    = 3'd0,
    ST_PLL_HOLD = 3'd1,
    ST_SYS_HOLD = 3'd2,
    ST_RUN      = 3'd3,
    ST_FAIL     = 3'd4
  } seqState_t;

  // Strobes from control to the delay counter.
  typedef struct packed {
    logic cntClr;
    logic cntEn;
  } seqCtl_t;

  // Conditioned inputs and compare results from the datapath.
  typedef struct packed {
    logic hitPll;
    logic hitSys;
    logic hitInit;
    logic lockAll;
    logic memDone;
  } seqFlags_t;

endpackage

// File: rtl/rstseq_sync2.sv
module rstseq_sync2 #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= {W{RST_VAL}};
      q      <= {W{RST_VAL}};
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/rstseq_datapath.sv
module rstseq_datapath
  import rstseq_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 50000,
  parameter int unsigned PLL_MS  = 1,
  parameter int unsigned SYS_MS  = 100,
  parameter int unsigned INIT_MS = 50,
  parameter int unsigned NUM_PLL = 2
) (
  input  logic               clk,
  input  logic               extRstN,
  input  logic [NUM_PLL-1:0] pllLocked,
  input  logic               memInitDone,
  input  seqCtl_t            ctl,
  output logic               localRstN,
  output seqFlags_t          flags
);

  localparam int unsigned PLL_CYC = CLK_KHZ * PLL_MS;
  localparam int unsigned SYS_CYC = CLK_KHZ * SYS_MS;
  localparam int unsigned INIT_CYC = CLK_KHZ * INIT_MS;
  localparam int unsigned MAX_CYC = (SYS_CYC > INIT_CYC) ? SYS_CYC : INIT_CYC;
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] PLL_LAST = CNT_W'(PLL_CYC - 1);
  localparam logic [CNT_W-1:0] SYS_LAST = CNT_W'(SYS_CYC - 1);
  localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_CYC - 1);

  logic [NUM_PLL-1:0] lockSync;
  logic               memSync;
  logic [CNT_W-1:0]   cnt;

  // Reset request: asynchronous assertion, release after two reference edges.
  rstseq_sync2 #(.W(1), .RST_VAL(1'b0)) uRstSync (
    .clk  (clk),
    .rstN (extRstN),
    .d    (1'b1),
    .q    (localRstN)
  );

  for (genvar i = 0; i < NUM_PLL; i++) begin : g_lock
    rstseq_sync2 #(.W(1), .RST_VAL(1'b0)) uLockSync (
      .clk  (clk),
      .rstN (localRstN),
      .d    (pllLocked[i]),
      .q    (lockSync[i])
    );
  end

  rstseq_sync2 #(.W(1), .RST_VAL(1'b0)) uMemSync (
    .clk  (clk),
    .rstN (localRstN),
    .d    (memInitDone),
    .q    (memSync)
  );

  // One shared, saturating delay counter serves every stage.
  always_ff @(posedge clk or negedge localRstN) begin
    if (!localRstN) begin
      cnt <= '0;
    end else if (ctl.cntClr) begin
      cnt <= '0;
    end else if (ctl.cntEn && cnt != CNT_TOP) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    flags.hitPll  = (cnt >= PLL_LAST);
    flags.hitSys  = (cnt >= SYS_LAST);
    flags.hitInit = (cnt >= INIT_LAST);
    flags.lockAll = &lockSync;
    flags.memDone = memSync;
  end

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int RETRY_ON_FAIL = 0
) (
  input  logic      clk,
  input  logic      localRstN,
  input  seqFlags_t flags,
  output seqCtl_t   ctl,
  output logic      pllRst,
  output logic      sysRst,
  output logic      initFail,
  output logic [2:0] seqState
);

  seqState_t stateQ, stateD;
  logic      lockSeenQ;
  logic      initSeenQ;
  logic      initFailQ;
  logic      pllRstQ;
  logic      sysRstQ;

  always_comb begin
    stateD = stateQ;
    ctl    = '0;
    case (stateQ)
      ST_RESET: begin
        ctl.cntClr = 1'b1;
        stateD     = ST_PLL_HOLD;
      end
      ST_PLL_HOLD: begin
        ctl.cntEn = 1'b1;
        if (flags.hitPll) stateD = ST_SYS_HOLD;
      end
      ST_SYS_HOLD: begin
        ctl.cntEn = 1'b1;
        if (lockSeenQ && !flags.lockAll) begin
          stateD = ST_RESET;
        end else if (flags.hitSys && flags.lockAll) begin
          stateD     = ST_RUN;
          ctl.cntClr = 1'b1;
        end
      end
      ST_RUN: begin
        if (!flags.lockAll) begin
          stateD = ST_RESET;
        end else if (!initSeenQ && !flags.memDone) begin
          ctl.cntEn = 1'b1;
          if (flags.hitInit) stateD = ST_FAIL;
        end
      end
      ST_FAIL: begin
        if (!flags.lockAll || RETRY_ON_FAIL != 0) stateD = ST_RESET;
      end
      default: stateD = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge localRstN) begin
    if (!localRstN) begin
      stateQ    <= ST_RESET;
      lockSeenQ <= 1'b0;
      initSeenQ <= 1'b0;
      initFailQ <= 1'b0;
      pllRstQ   <= 1'b1;
      sysRstQ   <= 1'b1;
    end else begin
      stateQ <= stateD;
      if (stateD == ST_RESET) begin
        lockSeenQ <= 1'b0;
      end else if (stateQ != ST_RESET && stateQ != ST_PLL_HOLD && flags.lockAll) begin
        lockSeenQ <= 1'b1;
      end
      if (stateD == ST_RESET) begin
        initSeenQ <= 1'b0;
      end else if (stateQ == ST_RUN && flags.memDone) begin
        initSeenQ <= 1'b1;
      end
      if (stateQ == ST_RUN && stateD == ST_FAIL) initFailQ <= 1'b1;
      pllRstQ <= (stateD == ST_RESET) || (stateD == ST_PLL_HOLD);
      sysRstQ <= !((stateD == ST_RUN) || (stateD == ST_FAIL));
    end
  end

  assign pllRst   = pllRstQ;
  assign sysRst   = sysRstQ;
  assign initFail = initFailQ;
  assign seqState = stateQ;

  a_r3_release_order: assert property (@(posedge clk) disable iff (!localRstN)
    !sysRstQ |-> !pllRstQ);

  a_r2_pll_after_count: assert property (@(posedge clk) disable iff (!localRstN)
    $fell(pllRstQ) |-> $past(flags.hitPll));

  a_r4_sys_needs_lock: assert property (@(posedge clk) disable iff (!localRstN)
    $fell(sysRstQ) |-> $past(flags.lockAll && flags.hitSys));

  a_r5_lock_loss: assert property (@(posedge clk) disable iff (!localRstN)
    (stateQ == ST_RUN && !flags.lockAll) |=> (stateQ == ST_RESET && pllRstQ && sysRstQ));

  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!localRstN)
    initFailQ |=> initFailQ);

  a_r7_fail_on_timeout: assert property (@(posedge clk) disable iff (!localRstN)
    $rose(initFailQ) |-> $past(flags.hitInit && !flags.memDone));

endmodule

// File: rtl/staged_reset_seq.sv
module staged_reset_seq
  import rstseq_pkg::*;
#(
  parameter int unsigned CLK_KHZ       = 50000,
  parameter int unsigned PLL_MS        = 1,
  parameter int unsigned SYS_MS        = 100,
  parameter int unsigned INIT_MS       = 50,
  parameter int unsigned NUM_PLL       = 2,
  parameter int          RETRY_ON_FAIL = 0
) (
  input  logic               clk,
  input  logic               extRstN,
  input  logic [NUM_PLL-1:0] pllLocked,
  input  logic               memInitDone,
  output logic               pllRst,
  output logic               sysRst,
  output logic               initFail,
  output logic [2:0]         seqState
);

  logic      localRstN;
  seqCtl_t   ctl;
  seqFlags_t flags;

  rstseq_datapath #(
    .CLK_KHZ (CLK_KHZ),
    .PLL_MS  (PLL_MS),
    .SYS_MS  (SYS_MS),
    .INIT_MS (INIT_MS),
    .NUM_PLL (NUM_PLL)
  ) uPath (
    .clk         (clk),
    .extRstN     (extRstN),
    .pllLocked   (pllLocked),
    .memInitDone (memInitDone),
    .ctl         (ctl),
    .localRstN   (localRstN),
    .flags       (flags)
  );

  rstseq_ctrl #(
    .RETRY_ON_FAIL (RETRY_ON_FAIL)
  ) uCtrl (
    .clk       (clk),
    .localRstN (localRstN),
    .flags     (flags),
    .ctl       (ctl),
    .pllRst    (pllRst),
    .sysRst    (sysRst),
    .initFail  (initFail),
    .seqState  (seqState)
  );

endmodule

// File: tb/tb_staged_reset_seq.sv
module tb_staged_reset_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_KHZ    = 10;
  localparam int PLL_MS     = 1;
  localparam int SYS_MS     = 5;
  localparam int INIT_MS    = 3;
  localparam int PLL_CYC    = CLK_KHZ * PLL_MS;
  localparam int SYS_CYC    = CLK_KHZ * SYS_MS;
  localparam int INIT_CYC   = CLK_KHZ * INIT_MS;

  logic       clk = 1'b0;
  logic       extRstN;
  logic [1:0] pllLocked;
  logic       memInitDone;
  logic       pllRst, sysRst, initFail;
  logic [2:0] seqState;
  logic       rPllRst, rSysRst, rInitFail;
  logic [2:0] rSeqState;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  staged_reset_seq #(
    .CLK_KHZ(CLK_KHZ), .PLL_MS(PLL_MS), .SYS_MS(SYS_MS), .INIT_MS(INIT_MS),
    .NUM_PLL(2), .RETRY_ON_FAIL(0)
  ) dut (
    .clk(clk), .extRstN(extRstN), .pllLocked(pllLocked), .memInitDone(memInitDone),
    .pllRst(pllRst), .sysRst(sysRst), .initFail(initFail), .seqState(seqState)
  );

  staged_reset_seq #(
    .CLK_KHZ(CLK_KHZ), .PLL_MS(PLL_MS), .SYS_MS(SYS_MS), .INIT_MS(INIT_MS),
    .NUM_PLL(2), .RETRY_ON_FAIL(1)
  ) dutRetry (
    .clk(clk), .extRstN(extRstN), .pllLocked(pllLocked), .memInitDone(memInitDone),
    .pllRst(rPllRst), .sysRst(rSysRst), .initFail(rInitFail), .seqState(rSeqState)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // R1: values held during reset
  task automatic t_reset;
    edges(4);
    chk("R1 pllRst in reset", pllRst, 1);
    chk("R1 sysRst in reset", sysRst, 1);
    chk("R1 state in reset", seqState, 0);
    chk("R1 initFail in reset", initFail, 0);
    chk("R1 retry instance sysRst", rSysRst, 1);
  endtask

  // R2, R3, R9: release timing and phase codes
  task automatic t_sequence;
    int pllK, sysK, st5, st20;
    pllK = -1; sysK = -1; st5 = -1; st20 = -1;
    @(negedge clk);
    memInitDone = 1'b1;
    extRstN = 1'b1;
    for (int k = 1; k <= SYS_CYC + 20; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 5) st5 = seqState;
      if (k == 20) st20 = seqState;
      if (pllK < 0 && !pllRst) pllK = k;
      if (sysK < 0 && !sysRst) sysK = k;
    end
    chk("R2 pllRst release edge", pllK, 3 + PLL_CYC);
    chk("R3 sysRst release edge", sysK, 3 + SYS_CYC);
    chk("R9 PLL-hold code", st5, 1);
    chk("R9 system-hold code", st20, 2);
    chk("R9 running code", seqState, 3);
  endtask

  // R6: memory done in time keeps running state
  task automatic t_init_ok;
    edges(INIT_CYC + 10);
    chk("R6 state stays running", seqState, 3);
    chk("R6 initFail stays low", initFail, 0);
    chk("R6 sysRst stays released", sysRst, 0);
  endtask

  // R1: assertion without a clock edge
  task automatic t_async;
    @(negedge clk);
    #(CLK_PERIOD/4);
    extRstN = 1'b0;
    #1;
    chk("R1 async pllRst", pllRst, 1);
    chk("R1 async sysRst", sysRst, 1);
    chk("R1 async state", seqState, 0);
    edges(3);
  endtask

  // R4: missing lock holds system reset
  task automatic t_lock_hold;
    int relK;
    relK = -1;
    @(negedge clk);
    pllLocked = 2'b01;
    extRstN = 1'b1;
    edges(SYS_CYC + 10);
    chk("R4 pllRst released without lock", pllRst, 0);
    chk("R4 sysRst held without lock", sysRst, 1);
    chk("R4 state system-hold", seqState, 2);
    pllLocked = 2'b11;
    for (int k = 1; k <= 10; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (relK < 0 && !sysRst) relK = k;
    end
    chk("R4 sysRst release after lock", relK, 3);
  endtask

  // R7, R8: timeout, sticky flag, retry
  task automatic t_init_fail;
    int sysK, failK, failInit, failSys, retPll, retSt, retIf;
    sysK = -1; failK = -1; failInit = -1; failSys = -1;
    retPll = -1; retSt = -1; retIf = -1;
    @(negedge clk);
    extRstN = 1'b0;
    memInitDone = 1'b0;
    edges(3);
    extRstN = 1'b1;
    for (int k = 1; k <= SYS_CYC + INIT_CYC + 10; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (sysK < 0 && !sysRst) sysK = k;
      if (failK >= 0 && k == failK + 1) begin
        retPll = rPllRst; retSt = rSeqState; retIf = rInitFail;
      end
      if (failK < 0 && seqState == 3'd4) begin
        failK = k; failInit = initFail; failSys = sysRst;
      end
    end
    chk("R7 sysRst release edge", sysK, 3 + SYS_CYC);
    chk("R7 timeout edge", failK, 3 + SYS_CYC + INIT_CYC);
    chk("R7 initFail raised", failInit, 1);
    chk("R7 sysRst stays released", failSys, 0);
    chk("R8 retry pllRst", retPll, 1);
    chk("R8 retry state", retSt, 0);
    chk("R8 retry keeps initFail", retIf, 1);
    edges(20);
    chk("R7 state stays failed", seqState, 4);
    chk("R7 initFail sticky", initFail, 1);
  endtask

  // R5: lock loss restarts the sequence
  task automatic t_lock_loss;
    @(negedge clk);
    pllLocked = 2'b10;
    edges(2);
    chk("R5 no restart before third edge", sysRst, 0);
    edges(1);
    chk("R5 pllRst reasserted", pllRst, 1);
    chk("R5 sysRst reasserted", sysRst, 1);
    chk("R5 state idle-reset", seqState, 0);
    chk("R7 initFail kept over restart", initFail, 1);
    pllLocked = 2'b11;
    memInitDone = 1'b1;
    edges(SYS_CYC + 15);
    chk("R5 sequence reran to running", seqState, 3);
    chk("R5 sysRst released again", sysRst, 0);
    chk("R7 initFail still set", initFail, 1);
  endtask

  // R7: only the external reset clears the flag
  task automatic t_clear;
    @(negedge clk);
    extRstN = 1'b0;
    #1;
    chk("R7 initFail cleared by external reset", initFail, 0);
    edges(2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    extRstN = 1'b0;
    pllLocked = 2'b11;
    memInitDone = 1'b0;
    t_reset();
    t_sequence();
    t_init_ok();
    t_async();
    t_lock_hold();
    t_init_fail();
    t_lock_loss();
    t_clear();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule